// File: doc/BRIEF.md
# UART Command Responder Sequencer

This block sits between a UART receiver and a UART transmitter. Each time the receiver reports a finished character, the block decides on a fixed four-byte ASCII reply and sends it to the transmitter one byte at a time. Every reply ends with carriage return and line feed. The reply depends on two things: the character itself, or the receive error reported with it.

The receiver side is a single-cycle strobe. The strobe carries the byte and three error flags: parity, framing and overrun. The flags count only in the cycle the strobe is high.

The transmitter side has three parts:
- a valid/ready handshake for each reply byte;
- a transmit-done pulse that the transmitter raises once it has finished putting a byte on the line;
- a `busy` output that stays high for the whole reply.

While a reply is in progress, every new receive strobe is dropped. Bit timing and the serial line are handled outside the block.

Top module: `uart_cmd_responder`

## Requirements
- R1: A strobe with byte 0x54 and no error flags produces the reply 0x4F, 0x4B, 0x0D, 0x0A.
- R2: A strobe with byte 0x74 and no error flags produces the reply 0x6F, 0x6B, 0x0D, 0x0A.
- R3: A strobe with any other byte and no error flags produces the reply 0x55, 0x43, 0x0D, 0x0A.
- R4: A strobe with exactly one error flag produces one of these replies:
  - parity: 0x50, 0x45, 0x0D, 0x0A;
  - framing: 0x46, 0x45, 0x0D, 0x0A;
  - overrun: 0x4F, 0x45, 0x0D, 0x0A.

  Error flags raised while the strobe is low have no effect.
- R5: When several error flags come with one strobe, only one is answered. Framing wins over parity, and parity wins over overrun.
- R6: The data byte that arrives with any error flag is discarded. Even 0x54 or 0x74 gets the error reply and not a character reply.
- R7: Any strobe is ignored while `busy` is high. This includes a strobe in the same cycle as the final transmit-done pulse.
- R8: Byte order and handshake rules:
  - The first reply byte is presented with `tx_valid` in the cycle after the accepted strobe.
  - Each later byte is presented in the cycle after a transmit-done pulse, and never before one.
  - While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R9: `busy` rises in the cycle after an accepted strobe. It stays high until the transmit-done pulse that follows the fourth handoff, and is low in the cycle after that pulse.
- R10: A synchronous active-high reset returns the block to idle, with `busy` and `tx_valid` low. This also cuts short a reply in progress, and the next strobe is then accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received character, meaningful with `rx_valid` |
| rx_err_parity | input | 1 | Parity error on this character |
| rx_err_framing | input | 1 | Framing error on this character |
| rx_err_overrun | input | 1 | Overrun error on this character |
| tx_valid | output | 1 | A reply byte is offered to the transmitter |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_done | input | 1 | Transmitter finished sending the last byte taken |
| busy | output | 1 | A reply is in progress; strobes are ignored |

## Verification
Assertions check the following on every cycle:
- the offered byte holds steady while `tx_ready` is low;
- nothing is offered while the block waits for transmit-done;
- a reply always starts from its first byte;
- an idle block always takes a strobe, and the reply it chose does not change while busy.

Only the bench scenarios can show the remaining behaviour:
- the byte values of each reply;
- the error priority;
- that data arriving with an error is discarded;
- that strobes arriving in the gaps and on the final transmit-done cycle leave no trace;
- recovery from a reset in mid-reply.

// File: rtl/uart_cmd_responder_pkg.sv
package uart_cmd_responder_pkg;

    localparam int BYTE_W    = 8;
    localparam int REPLY_LEN = 4;
    localparam int IDX_W     = $clog2(REPLY_LEN);

    localparam logic [BYTE_W-1:0] CH_UPPER_T = 8'h54;
    localparam logic [BYTE_W-1:0] CH_LOWER_T = 8'h74;

    typedef enum logic [2:0] {
        RK_ACK_UPPER = 3'd0,
        RK_ACK_LOWER = 3'd1,
        RK_UNKNOWN   = 3'd2,
        RK_ERR_PAR   = 3'd3,
        RK_ERR_FRM   = 3'd4,
        RK_ERR_OVR   = 3'd5
    } reply_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_OFFER = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic [IDX_W-1:0] idx;
        reply_kind_e kind;
    } seq_regs_t;

    // Leading character of each reply.
    function automatic logic [BYTE_W-1:0] lead_char(reply_kind_e k);
        case (k)
            RK_ACK_UPPER: return 8'h4F;
            RK_ACK_LOWER: return 8'h6F;
            RK_UNKNOWN:   return 8'h55;
            RK_ERR_PAR:   return 8'h50;
            RK_ERR_FRM:   return 8'h46;
            default:      return 8'h4F;
        endcase
    endfunction

    // Second character of each reply.
    function automatic logic [BYTE_W-1:0] tail_char(reply_kind_e k);
        case (k)
            RK_ACK_UPPER: return 8'h4B;
            RK_ACK_LOWER: return 8'h6B;
            RK_UNKNOWN:   return 8'h43;
            default:      return 8'h45;
        endcase
    endfunction

endpackage

// File: rtl/uart_cmd_classifier.sv
module uart_cmd_classifier
    import uart_cmd_responder_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic              err_parity,
    input  logic              err_framing,
    input  logic              err_overrun,
    output reply_kind_e       kind
);
    // Errors outrank data; among errors framing, then parity, then overrun.
    always_comb begin
        if (err_framing) begin
            kind = RK_ERR_FRM;
        end else if (err_parity) begin
            kind = RK_ERR_PAR;
        end else if (err_overrun) begin
            kind = RK_ERR_OVR;
        end else if (data == CH_UPPER_T) begin
            kind = RK_ACK_UPPER;
        end else if (data == CH_LOWER_T) begin
            kind = RK_ACK_LOWER;
        end else begin
            kind = RK_UNKNOWN;
        end
    end
endmodule

// File: rtl/uart_reply_rom.sv
module uart_reply_rom
    import uart_cmd_responder_pkg::*;
(
    input  reply_kind_e       kind,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] byte_out
);
    localparam logic [BYTE_W-1:0] CH_CR = 8'h0D;
    localparam logic [BYTE_W-1:0] CH_LF = 8'h0A;

    always_comb begin
        case (idx)
            IDX_W'(0): byte_out = lead_char(kind);
            IDX_W'(1): byte_out = tail_char(kind);
            IDX_W'(2): byte_out = CH_CR;
            default:   byte_out = CH_LF;
        endcase
    end
endmodule

// File: rtl/uart_reply_sequencer.sv
module uart_reply_sequencer
    import uart_cmd_responder_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  reply_kind_e      evt_kind,
    input  logic             tx_ready,
    input  logic             tx_done,
    output logic             offer,
    output logic             busy,
    output reply_kind_e      cur_kind,
    output logic [IDX_W-1:0] cur_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REPLY_LEN - 1);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            SQ_IDLE: begin
                if (evt_valid) begin
                    r_d.state = SQ_OFFER;
                    r_d.idx   = '0;
                    r_d.kind  = evt_kind;
                end
            end
            SQ_OFFER: begin
                if (tx_ready) begin
                    r_d.state = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (tx_done) begin
                    if (r_q.idx == LAST_IDX) begin
                        r_d.state = SQ_IDLE;
                        r_d.idx   = '0;
                    end else begin
                        r_d.state = SQ_OFFER;
                        r_d.idx   = r_q.idx + IDX_W'(1);
                    end
                end
            end
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= SQ_IDLE;
            r_q.idx   <= '0;
            r_q.kind  <= RK_UNKNOWN;
        end else begin
            r_q <= r_d;
        end
    end

    assign offer    = (r_q.state == SQ_OFFER);
    assign busy     = (r_q.state != SQ_IDLE);
    assign cur_kind = r_q.kind;
    assign cur_idx  = r_q.idx;

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        offer && !tx_ready |=> offer && $stable(cur_idx) && $stable(cur_kind)); // R8
    AST_NO_OFFER_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == SQ_WAIT) && !tx_done |=> !offer); // R8
    AST_START_AT_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> offer && (cur_idx == '0)); // R8
    AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        !busy && evt_valid |=> busy && (cur_kind == $past(evt_kind))); // R9
    AST_KIND_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_kind)); // R7
endmodule

// File: rtl/uart_cmd_responder.sv
module uart_cmd_responder
    import uart_cmd_responder_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_err_parity,
    input  logic              rx_err_framing,
    input  logic              rx_err_overrun,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              tx_done,
    output logic              busy
);
    reply_kind_e      evt_kind;
    reply_kind_e      cur_kind;
    logic [IDX_W-1:0] cur_idx;

    uart_cmd_classifier u_classify (
        .data        (rx_data),
        .err_parity  (rx_err_parity),
        .err_framing (rx_err_framing),
        .err_overrun (rx_err_overrun),
        .kind        (evt_kind)
    );

    uart_reply_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (rx_valid),
        .evt_kind  (evt_kind),
        .tx_ready  (tx_ready),
        .tx_done   (tx_done),
        .offer     (tx_valid),
        .busy      (busy),
        .cur_kind  (cur_kind),
        .cur_idx   (cur_idx)
    );

    uart_reply_rom u_rom (
        .kind     (cur_kind),
        .idx      (cur_idx),
        .byte_out (tx_data)
    );

    AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy); // R9
endmodule

// File: tb/uart_cmd_responder_tb.sv
`timescale 1ns/1ps
module uart_cmd_responder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_err_parity, rx_err_framing, rx_err_overrun;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready, tx_done;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uart_cmd_responder u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err_parity(rx_err_parity), .rx_err_framing(rx_err_framing),
        .rx_err_overrun(rx_err_overrun), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_done(tx_done), .busy(busy)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected reply byte from the requirement tables.
    function automatic logic [7:0] exp_byte(logic [7:0] d, bit f, bit p, bit o, int i);
        logic [7:0] a, b;
        if (i == 2) return 8'h0D;
        if (i == 3) return 8'h0A;
        if (f)              begin a = 8'h46; b = 8'h45; end
        else if (p)         begin a = 8'h50; b = 8'h45; end
        else if (o)         begin a = 8'h4F; b = 8'h45; end
        else if (d == 8'h54) begin a = 8'h4F; b = 8'h4B; end
        else if (d == 8'h74) begin a = 8'h6F; b = 8'h6B; end
        else                begin a = 8'h55; b = 8'h43; end
        return (i == 0) ? a : b;
    endfunction

    function automatic string tag(logic [7:0] d, bit f, bit p, bit o);
        int n = int'(f) + int'(p) + int'(o);
        if (n > 1) return "R5";
        if (n == 1 && (d == 8'h54 || d == 8'h74)) return "R6";
        if (n == 1) return "R4";
        if (d == 8'h54) return "R1";
        if (d == 8'h74) return "R2";
        return "R3";
    endfunction

    task automatic idle_inputs();
        rx_valid = 0; rx_err_parity = 0; rx_err_framing = 0; rx_err_overrun = 0;
        tx_ready = 0; tx_done = 0;
    endtask

    // Drive one strobe and play the transmitter for the whole reply.
    task automatic run_reply(logic [7:0] d, bit f, bit p, bit o, bit stray);
        string t = tag(d, f, p, o);
        logic [7:0] held;
        @(negedge clk);
        rx_valid = 1; rx_data = d;
        rx_err_framing = f; rx_err_parity = p; rx_err_overrun = o;
        @(negedge clk);
        idle_inputs(); rx_data = 8'($urandom);
        for (int i = 0; i < 4; i++) begin
            chk(tx_valid === 1'b1, "R8", "byte offered", int'(tx_valid), 1);
            chk(tx_data === exp_byte(d, f, p, o, i), t, "reply byte",
                int'(tx_data), int'(exp_byte(d, f, p, o, i)));
            chk(busy === 1'b1, "R9", "busy during reply", int'(busy), 1);
            held = tx_data;
            for (int h = 0; h < int'($urandom % 3); h++) begin
                @(negedge clk);
                chk(tx_valid === 1'b1 && tx_data === held, "R8", "hold while not ready",
                    int'(tx_data), int'(held));
            end
            tx_ready = 1;
            @(negedge clk);
            tx_ready = 0;
            for (int g = 0; g < 1 + int'($urandom % 4); g++) begin
                if (stray) begin
                    rx_valid = 1; rx_data = 8'h74; rx_err_parity = 1'($urandom);
                end
                @(negedge clk);
                rx_valid = 0; rx_err_parity = 0;
                chk(tx_valid === 1'b0, "R8", "no offer before done", int'(tx_valid), 0);
                chk(busy === 1'b1, "R7", "stray strobe keeps reply", int'(busy), 1);
            end
            tx_done = 1;
            if (i == 3 && stray) begin rx_valid = 1; rx_data = 8'h54; end
            @(negedge clk);
            tx_done = 0; rx_valid = 0;
        end
        chk(busy === 1'b0, "R9", "busy low after last done", int'(busy), 0);
        chk(tx_valid === 1'b0, "R7", "no reply after final-cycle strobe", int'(tx_valid), 0);
        @(negedge clk);
        chk(busy === 1'b0, "R7", "strobe on final done ignored", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs(); rx_data = 0; rst = 1;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && tx_valid === 1'b0, "R10", "reset state",
            int'({busy, tx_valid}), 0);
        rst = 0;
        @(negedge clk);

        // Error flags without strobe must not start a reply.
        rx_err_framing = 1; rx_err_parity = 1; rx_err_overrun = 1;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk(busy === 1'b0, "R4", "flags without strobe ignored", int'(busy), 0);

        run_reply(8'h54, 0, 0, 0, 0);
        run_reply(8'h74, 0, 0, 0, 1);
        run_reply(8'h41, 0, 0, 0, 0);
        run_reply(8'h00, 0, 1, 0, 0);
        run_reply(8'h33, 1, 0, 0, 1);
        run_reply(8'hFF, 0, 0, 1, 0);
        run_reply(8'h54, 0, 1, 0, 0);
        run_reply(8'h74, 0, 0, 1, 0);
        run_reply(8'h10, 1, 1, 1, 0);
        run_reply(8'h20, 0, 1, 1, 1);
        run_reply(8'h54, 1, 0, 1, 0);

        // Reset in mid-reply.
        @(negedge clk);
        rx_valid = 1; rx_data = 8'h54;
        @(negedge clk);
        rx_valid = 0; tx_ready = 1;
        @(negedge clk);
        tx_ready = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        chk(busy === 1'b0 && tx_valid === 1'b0, "R10", "reset aborts reply",
            int'({busy, tx_valid}), 0);
        run_reply(8'h74, 0, 0, 0, 0);

        for (int n = 0; n < 60; n++) begin
            logic [7:0] d;
            int sel = int'($urandom % 4);
            d = (sel == 0) ? 8'h54 : (sel == 1) ? 8'h74 : 8'($urandom);
            run_reply(d, ($urandom % 5) == 0, ($urandom % 5) == 0,
                      ($urandom % 5) == 0, 1'($urandom));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule